// File: doc/BRIEF.md
# PWM Slice with Fractional Clock Divider

This block is a single pulse-width modulation slice. A phase-accumulating divider turns the system clock into count steps. The divisor has an integer part and a fractional part, so the average step rate can be set finer than whole clocks. The steps drive a counter that climbs to a programmable top value. In normal mode it then restarts from zero. In phase-correct mode it reverses and walks back down, which gives centre-aligned pulses at half the frequency. Two outputs, A and B, are each high while the counter is below their own compare threshold. Each output can be inverted.

Software configures the slice through a narrow write port: control, divisor, counter, compare pair, top, slice enable and the interrupt fields. The divider can also be fed from the B pin instead of running free. In that case it counts only while B is high, or once per rising edge, or once per falling edge of B. Two write-only strobes nudge the counter phase one count forward or one count back. Every counter wrap raises an interrupt. The interrupt can be enabled, forced and cleared.

Compare and top values are double-buffered. While the slice is stopped, a write takes effect one cycle later. While it runs, the new value waits for the next wrap point, so a period is never cut short or glitched.

Top module: `pwm_slice`

## Requirements
- R1: After reset the counter reads 0, both outputs are low, both interrupt outputs are low, top is all ones and the divisor is 0x010 (divide by 1).
- R2: Write address 1 holds the divisor, with the integer part in bits 11:4 and the fraction in bits 3:0. Step rate = clock / (INT + FRAC/16). An integer part of 0 means 256. Divisor 0x018 gives exactly 20 steps in any 30 free-running clocks, and divisor 0x000 gives one step every 256 clocks.
- R3: In normal mode (control bit 1 = 0) each step adds one to the counter. A step taken when the counter is at or above top sets the counter to 0 instead, and this is the wrap.
- R4: In phase-correct mode (control bit 1 = 1) the counter climbs to top, holds there for one step, descends to 0 and holds there for one step. The period is 2*(top+1) steps. The wrap is the step that turns the counter back up at 0.
- R5: Output A is high while the counter is below compare A (write address 3, bits 15:0). Output B uses compare B (bits 31:16). A compare above top gives 100 % duty, and a compare of 0 gives 0 %.
- R6: Control bit 2 inverts A and control bit 3 inverts B. While the slice is stopped, each output sits at its invert bit.
- R7: When compare or top is written while the slice runs, the new value is used only from the next wrap. The current period finishes with the old values.
- R8: Divider mode 1 (control bits 5:4 = 01) lets the divider advance only while the B input, after a two-flop synchroniser, is high. With B low the counter holds.
- R9: Divider mode 2 (10) advances the divider once per synchronised rising edge of B. Mode 3 (11) advances it once per falling edge.
- R10: Writing control with bit 7 set while running adds one extra count. Writing control with bit 6 set while running swallows the next count. Neither bit is stored.
- R11: A wrap sets the raw interrupt. Writing 1 to bit 0 at address 6 clears it. Address 7 is the enable and address 8 is the force. The interrupt output is (raw OR force) AND enable.
- R12: The slice runs when control bit 0 or the slice enable bit (address 5, bit 0) is set. While it is stopped the counter holds.
- R13: Writing address 2 loads the counter directly. The new value is visible one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register select |
| wr_data | input | 32 | Write data |
| pin_b_in | input | 1 | B pin input for gated or edge-counted clocking |
| out_a | output | 1 | PWM output A |
| out_b | output | 1 | PWM output B |
| count_o | output | 16 | Current counter value |
| irq_raw_o | output | 1 | Raw wrap interrupt |
| irq_o | output | 1 | Masked interrupt |

## Verification
The bench builds the slice with its default parameters: a 16-bit counter and an 8.4 divisor. It programs top values of 2 to 9, so wraps, turnarounds and reload points occur every few cycles. The full 8-bit integer field lets the bench reach the integer-zero case (256 clocks per step) in under a thousand cycles. The 4-bit fraction lets it check an exact step count over a 30-cycle window. A behavioural model tracks every control path, including the B synchroniser delay and the phase strobes, and the bench compares it with the outputs each cycle.

// File: rtl/pwm_slice_pkg.sv
package pwm_slice_pkg;

  typedef enum logic [1:0] {
    DM_FREE  = 2'd0,
    DM_LEVEL = 2'd1,
    DM_RISE  = 2'd2,
    DM_FALL  = 2'd3
  } divmode_e;

  // stored control fields; bits 7 and 6 of a control write are strobes
  typedef struct packed {
    divmode_e mode;   // 5:4
    logic     inv_b;  // 3
    logic     inv_a;  // 2
    logic     pc;     // 1
    logic     en;     // 0
  } ctrl_t;

  localparam int REG_CTRL = 0;
  localparam int REG_DIV  = 1;
  localparam int REG_CNT  = 2;
  localparam int REG_CMP  = 3;
  localparam int REG_TOP  = 4;
  localparam int REG_GEN  = 5;
  localparam int REG_RAW  = 6;
  localparam int REG_IEN  = 7;
  localparam int REG_IFRC = 8;

  localparam int STB_RET_BIT = 6;
  localparam int STB_ADV_BIT = 7;

endpackage

// File: rtl/pwm_frac_div.sv
module pwm_frac_div
  import pwm_slice_pkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  divmode_e          mode,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  input  logic              pin_b,
  output logic              tick
);
  localparam int ACC_W = INT_W + FRAC_W + 1;
  localparam logic [ACC_W-1:0] UNIT = ACC_W'(1) << FRAC_W;

  logic [2:0]       b_q, b_d;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W-1:0] int_eff, div_eff, acc_sum;
  logic             step_en;

  always_comb begin
    b_d = {b_q[1:0], pin_b};
    unique case (mode)
      DM_FREE:  step_en = 1'b1;
      DM_LEVEL: step_en = b_q[1];
      DM_RISE:  step_en = b_q[1] & ~b_q[2];
      default:  step_en = ~b_q[1] & b_q[2];
    endcase
    step_en = step_en & run;
    int_eff = (div_int == '0) ? ACC_W'(1 << INT_W) : ACC_W'(div_int);
    div_eff = (int_eff << FRAC_W) | ACC_W'(div_frac);
    acc_sum = acc_q + UNIT;
    tick    = step_en && (acc_sum >= div_eff);
    if (!run)         acc_d = '0;
    else if (tick)    acc_d = acc_sum - div_eff;
    else if (step_en) acc_d = acc_sum;
    else              acc_d = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q   <= '0;
      acc_q <= '0;
    end else begin
      b_q   <= b_d;
      acc_q <= acc_d;
    end
  end

  assert_unit_div_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && div_eff == UNIT) |-> tick);

endmodule

// File: rtl/pwm_phase_ctr.sv
module pwm_phase_ctr #(
  parameter int CNT_W = 16,
  parameter int NCH   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run,
  input  logic                      pc,
  input  logic                      tick,
  input  logic                      adv_req,
  input  logic                      ret_req,
  input  logic                      cnt_wr,
  input  logic [CNT_W-1:0]          cnt_wdata,
  input  logic [CNT_W-1:0]          top_new,
  input  logic [NCH-1:0][CNT_W-1:0] cmp_new,
  output logic [CNT_W-1:0]          cnt,
  output logic [NCH-1:0][CNT_W-1:0] cmp_sh,
  output logic                      wrap
);
  logic [CNT_W-1:0]          cnt_d, top_sh, top_sh_d;
  logic [NCH-1:0][CNT_W-1:0] cmp_sh_d;
  logic dir_dn, dir_dn_d, ret_pend, ret_d, adv_pend, adv_d, step, reload;

  always_comb begin
    step  = (tick & ~ret_pend) | (adv_pend & ~tick);
    wrap  = run && step && !cnt_wr &&
            (pc ? (dir_dn && cnt == '0) : (cnt >= top_sh));
    cnt_d    = cnt;
    dir_dn_d = pc ? dir_dn : 1'b0;
    if (cnt_wr) begin
      cnt_d = cnt_wdata;
    end else if (run && step) begin
      if (!pc) begin
        cnt_d = (cnt >= top_sh) ? '0 : cnt + 1'b1;
      end else if (!dir_dn) begin
        if (cnt >= top_sh) dir_dn_d = 1'b1;
        else               cnt_d    = cnt + 1'b1;
      end else begin
        if (cnt == '0) dir_dn_d = 1'b0;
        else           cnt_d    = cnt - 1'b1;
      end
    end
    ret_d    = run & ((ret_pend & ~tick) | ret_req);
    adv_d    = run & ((adv_pend & tick) | adv_req);
    reload   = !run || wrap;
    top_sh_d = reload ? top_new : top_sh;
    cmp_sh_d = reload ? cmp_new : cmp_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      dir_dn   <= 1'b0;
      ret_pend <= 1'b0;
      adv_pend <= 1'b0;
      top_sh   <= '1;
      cmp_sh   <= '0;
    end else begin
      cnt      <= cnt_d;
      dir_dn   <= dir_dn_d;
      ret_pend <= ret_d;
      adv_pend <= adv_d;
      top_sh   <= top_sh_d;
      cmp_sh   <= cmp_sh_d;
    end
  end

  assert_up_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pc && step && !cnt_wr && cnt < top_sh) |=> cnt == $past(cnt) + 1'b1);

  assert_turn_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && pc) |=> !dir_dn);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt));

  assert_retard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_pend && tick && !ret_req) |=> !ret_pend);

endmodule

// File: rtl/pwm_irq_ctl.sv
module pwm_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic clr_hit,
  input  logic ien_hit,
  input  logic frc_hit,
  input  logic wbit,
  output logic irq_raw,
  output logic irq
);
  logic raw_d, ien_q, ien_d, frc_q, frc_d;

  always_comb begin
    raw_d = wrap | (irq_raw & ~(clr_hit & wbit));
    ien_d = ien_hit ? wbit : ien_q;
    frc_d = frc_hit ? wbit : frc_q;
    irq   = (irq_raw | frc_q) & ien_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_raw <= 1'b0;
      ien_q   <= 1'b0;
      frc_q   <= 1'b0;
    end else begin
      irq_raw <= raw_d;
      ien_q   <= ien_d;
      frc_q   <= frc_d;
    end
  end

  assert_raw_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> irq_raw);

endmodule

// File: rtl/pwm_slice.sv
module pwm_slice
  import pwm_slice_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4,
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [2*CNT_W-1:0]   wr_data,
  input  logic                 pin_b_in,
  output logic                 out_a,
  output logic                 out_b,
  output logic [CNT_W-1:0]     count_o,
  output logic                 irq_raw_o,
  output logic                 irq_o
);
  localparam int NCH   = 2;
  localparam int DIV_W = INT_W + FRAC_W;
  localparam int CTL_W = $bits(ctrl_t);

  ctrl_t                     ctrl_q, ctrl_d;
  logic [DIV_W-1:0]          div_q, div_d;
  logic [CNT_W-1:0]          top_q, top_d;
  logic [NCH-1:0][CNT_W-1:0] cmp_q, cmp_d, cmp_sh;
  logic                      gen_q, gen_d;
  logic                      run, tick, wrap;
  logic                      hit_ctrl, hit_div, hit_cnt, hit_cmp, hit_top, hit_gen;
  logic [NCH-1:0]            inv, out_vec;

  always_comb begin
    hit_ctrl = wr_en && (wr_addr == ADDR_W'(REG_CTRL));
    hit_div  = wr_en && (wr_addr == ADDR_W'(REG_DIV));
    hit_cnt  = wr_en && (wr_addr == ADDR_W'(REG_CNT));
    hit_cmp  = wr_en && (wr_addr == ADDR_W'(REG_CMP));
    hit_top  = wr_en && (wr_addr == ADDR_W'(REG_TOP));
    hit_gen  = wr_en && (wr_addr == ADDR_W'(REG_GEN));
    ctrl_d   = hit_ctrl ? ctrl_t'(wr_data[CTL_W-1:0]) : ctrl_q;
    div_d    = hit_div  ? wr_data[DIV_W-1:0] : div_q;
    top_d    = hit_top  ? wr_data[CNT_W-1:0] : top_q;
    gen_d    = hit_gen  ? wr_data[0] : gen_q;
    cmp_d    = cmp_q;
    if (hit_cmp) cmp_d = wr_data;
    run = ctrl_q.en | gen_q;
    inv = {ctrl_q.inv_b, ctrl_q.inv_a};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= DIV_W'(1) << FRAC_W;
      top_q  <= '1;
      cmp_q  <= '0;
      gen_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      div_q  <= div_d;
      top_q  <= top_d;
      cmp_q  <= cmp_d;
      gen_q  <= gen_d;
    end
  end

  pwm_frac_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .mode     (ctrl_q.mode),
    .div_int  (div_q[DIV_W-1:FRAC_W]),
    .div_frac (div_q[FRAC_W-1:0]),
    .pin_b    (pin_b_in),
    .tick     (tick)
  );

  pwm_phase_ctr #(.CNT_W(CNT_W), .NCH(NCH)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .pc        (ctrl_q.pc),
    .tick      (tick),
    .adv_req   (hit_ctrl & wr_data[STB_ADV_BIT] & run),
    .ret_req   (hit_ctrl & wr_data[STB_RET_BIT] & run),
    .cnt_wr    (hit_cnt),
    .cnt_wdata (wr_data[CNT_W-1:0]),
    .top_new   (top_q),
    .cmp_new   (cmp_q),
    .cnt       (count_o),
    .cmp_sh    (cmp_sh),
    .wrap      (wrap)
  );

  pwm_irq_ctl u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrap    (wrap),
    .clr_hit (wr_en && (wr_addr == ADDR_W'(REG_RAW))),
    .ien_hit (wr_en && (wr_addr == ADDR_W'(REG_IEN))),
    .frc_hit (wr_en && (wr_addr == ADDR_W'(REG_IFRC))),
    .wbit    (wr_data[0]),
    .irq_raw (irq_raw_o),
    .irq     (irq_o)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    assign out_vec[ch] = run ? ((count_o < cmp_sh[ch]) ^ inv[ch]) : inv[ch];
  end

  assign out_a = out_vec[0];
  assign out_b = out_vec[1];

endmodule

// File: tb/sim_pwm_slice.sv
module sim_pwm_slice;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic        pin_b_in;
  logic        out_a, out_b, irq_raw_o, irq_o;
  logic [15:0] count_o;

  int    n_chk = 0;
  int    n_err = 0;
  string cur_req = "R1";
  bit    chk_on = 0;

  pwm_slice u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pin_b_in(pin_b_in), .out_a(out_a), .out_b(out_b),
    .count_o(count_o), .irq_raw_o(irq_raw_o), .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [5:0]  m_ctrl;
  logic [11:0] m_div;
  logic [15:0] m_top, m_ca, m_cb, m_cnt, m_tsh, m_ash, m_bsh;
  bit m_gen, m_ien, m_frc, m_raw, m_dir, m_ret, m_adv, m_b1, m_b2, m_b3;
  int m_acc;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_div = 12'h010; m_top = 16'hFFFF; m_ca = 0; m_cb = 0;
      m_cnt = 0; m_tsh = 16'hFFFF; m_ash = 0; m_bsh = 0;
      m_gen = 0; m_ien = 0; m_frc = 0; m_raw = 0; m_dir = 0; m_ret = 0; m_adv = 0;
      m_b1 = 0; m_b2 = 0; m_b3 = 0; m_acc = 0;
    end else begin
      bit run, pc, sen, tk, st, wrp, ndir;
      int de, nacc, ipart;
      logic [15:0] ncnt;
      run = m_ctrl[0] | m_gen;
      pc  = m_ctrl[1];
      case (m_ctrl[5:4])
        2'd0: sen = 1;
        2'd1: sen = m_b2;
        2'd2: sen = m_b2 && !m_b3;
        default: sen = !m_b2 && m_b3;
      endcase
      sen = sen && run;
      ipart = (m_div[11:4] == 0) ? 256 : int'(m_div[11:4]);
      de = ipart * 16 + int'(m_div[3:0]);
      tk = 0;
      if (!run) nacc = 0;
      else if (sen) begin
        nacc = m_acc + 16;
        if (nacc >= de) begin tk = 1; nacc = nacc - de; end
      end else nacc = m_acc;
      st = (tk && !m_ret) || (m_adv && !tk);
      ncnt = m_cnt; ndir = pc ? m_dir : 0; wrp = 0;
      if (wr_en && wr_addr == 2) ncnt = wr_data[15:0];
      else if (run && st) begin
        if (!pc) begin
          if (m_cnt >= m_tsh) begin ncnt = 0; wrp = 1; end
          else ncnt = 16'(m_cnt + 1);
        end else if (!m_dir) begin
          if (m_cnt >= m_tsh) ndir = 1; else ncnt = 16'(m_cnt + 1);
        end else begin
          if (m_cnt == 0) begin ndir = 0; wrp = 1; end
          else ncnt = 16'(m_cnt - 1);
        end
      end
      if (!run || wrp) begin m_tsh = m_top; m_ash = m_ca; m_bsh = m_cb; end
      m_raw = wrp || (m_raw && !(wr_en && wr_addr == 6 && wr_data[0]));
      m_ret = run && ((m_ret && !tk) || (wr_en && wr_addr == 0 && wr_data[6]));
      m_adv = run && ((m_adv && tk) || (wr_en && wr_addr == 0 && wr_data[7]));
      m_cnt = ncnt; m_dir = ndir; m_acc = nacc;
      m_b3 = m_b2; m_b2 = m_b1; m_b1 = pin_b_in;
      if (wr_en) begin
        case (wr_addr)
          4'd0: m_ctrl = wr_data[5:0];
          4'd1: m_div  = wr_data[11:0];
          4'd3: begin m_ca = wr_data[15:0]; m_cb = wr_data[31:16]; end
          4'd4: m_top  = wr_data[15:0];
          4'd5: m_gen  = wr_data[0];
          4'd7: m_ien  = wr_data[0];
          4'd8: m_frc  = wr_data[0];
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      bit run, ea, eb;
      run = m_ctrl[0] | m_gen;
      ea = run ? ((m_cnt < m_ash) ^ m_ctrl[2]) : m_ctrl[2];
      eb = run ? ((m_cnt < m_bsh) ^ m_ctrl[3]) : m_ctrl[3];
      check(cur_req, "model count", int'(count_o), int'(m_cnt));
      check(cur_req, "model out_a", int'(out_a), int'(ea));
      check(cur_req, "model out_b", int'(out_b), int'(eb));
      check(cur_req, "model irq_raw", int'(irq_raw_o), int'(m_raw));
      check(cur_req, "model irq", int'(irq_o), int'((m_raw | m_frc) & m_ien));
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #2;
    wr_en = 1; wr_addr = 4'(a); wr_data = d;
    @(posedge clk); #2;
    wr_en = 0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2 pin_b_in = 1;
      repeat (3) @(posedge clk);
      #2 pin_b_in = 0;
      repeat (2) @(posedge clk);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    int s[16];
    int c0, ha, hb, z, t, mx;
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; pin_b_in = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    cyc(1);
    cur_req = "R1";
    check("R1", "reset count", int'(count_o), 0);
    check("R1", "reset out_a", int'(out_a), 0);
    check("R1", "reset out_b", int'(out_b), 0);
    check("R1", "reset irq", int'(irq_o | irq_raw_o), 0);
    chk_on = 1;

    // R3 normal wrap, R5 duty
    cur_req = "R3";
    wr(4, 4); wr(3, {16'd5, 16'd2}); wr(0, 1);
    cyc(8);
    for (int i = 0; i < 10; i++) begin s[i] = int'(count_o); cyc(1); end
    for (int i = 1; i < 10; i++) check("R3", "wrap sequence", s[i], (s[i-1] + 1) % 5);
    cur_req = "R5";
    ha = 0; hb = 0;
    for (int i = 0; i < 5; i++) begin ha += int'(out_a); hb += int'(out_b); cyc(1); end
    check("R5", "duty A cmp=2 top=4", ha, 2);
    check("R5", "duty B cmp>top", hb, 5);

    // R6 inversion and idle level
    cur_req = "R6";
    wr(0, 32'h5); cyc(2);
    ha = 0;
    for (int i = 0; i < 5; i++) begin ha += int'(out_a); cyc(1); end
    check("R6", "inverted duty A", ha, 3);
    wr(0, 32'hC); cyc(2);
    check("R6", "idle A", int'(out_a), 1);
    check("R6", "idle B", int'(out_b), 1);

    // R4 phase-correct
    cur_req = "R4";
    wr(2, 0); wr(4, 3); wr(0, 3);
    cyc(4);
    for (int i = 0; i < 16; i++) begin s[i] = int'(count_o); cyc(1); end
    for (int i = 0; i < 8; i++) check("R4", "period 8", s[i+8], s[i]);
    z = 0; t = 0;
    for (int i = 0; i < 8; i++) begin z += (s[i] == 0); t += (s[i] == 3); end
    check("R4", "zero dwell", z, 2);
    check("R4", "top dwell", t, 2);

    // R2 divisor
    cur_req = "R2";
    wr(0, 0); wr(4, 16'hFFFF); wr(2, 0); wr(1, 0); wr(0, 1);
    cyc(770);
    check("R2", "int 0 as 256", int'(count_o), 3);
    wr(0, 0); wr(1, 12'h018); wr(2, 0); wr(0, 1);
    cyc(10); c0 = int'(count_o); cyc(30);
    check("R2", "div 1.5 over 30", int'(count_o) - c0, 20);

    // R7 shadowed compare and top
    cur_req = "R7";
    wr(0, 0); wr(1, 12'h010); wr(4, 9); wr(3, {16'd9, 16'd5}); wr(2, 0); wr(0, 1);
    for (int k = 0; k < 40 && count_o != 2; k++) cyc(1);
    wr(3, {16'd9, 16'd8});
    for (int k = 0; k < 40 && count_o != 7; k++) cyc(1);
    check("R7", "old compare kept", int'(out_a), 0);
    for (int k = 0; k < 40 && count_o != 0; k++) cyc(1);
    for (int k = 0; k < 40 && count_o != 7; k++) cyc(1);
    check("R7", "new compare after wrap", int'(out_a), 1);
    for (int k = 0; k < 40 && count_o != 3; k++) cyc(1);
    wr(4, 2);
    mx = 0;
    for (int k = 0; k < 40 && count_o != 0; k++) begin
      if (int'(count_o) > mx) mx = int'(count_o);
      cyc(1);
    end
    check("R7", "old top finishes", mx, 9);
    cyc(1); mx = 0;
    for (int k = 0; k < 40 && count_o != 0; k++) begin
      if (int'(count_o) > mx) mx = int'(count_o);
      cyc(1);
    end
    check("R7", "new top", mx, 2);

    // R13 counter load
    cur_req = "R13";
    wr(0, 0); wr(4, 16'hFFFF); wr(2, 6); cyc(1);
    check("R13", "counter load", int'(count_o), 6);

    // R12 slice enable
    cur_req = "R12";
    wr(5, 1); cyc(5);
    check("R12", "runs on slice enable", int'(count_o != 6), 1);
    wr(5, 0); cyc(1); c0 = int'(count_o); cyc(5);
    check("R12", "holds when stopped", int'(count_o), c0);

    // R10 phase nudges
    cur_req = "R10";
    wr(2, 0); wr(1, 12'h040); wr(0, 1);
    cyc(20); c0 = int'(count_o);
    wr(0, 32'h81); cyc(39);
    check("R10", "advance adds one", int'(count_o) - c0, 11);
    c0 = int'(count_o);
    wr(0, 32'h41); cyc(39);
    check("R10", "retard drops one", int'(count_o) - c0, 9);

    // R8 level gating
    cur_req = "R8";
    wr(0, 0); wr(1, 12'h010); wr(0, 32'h11);
    cyc(5); c0 = int'(count_o); cyc(10);
    check("R8", "hold while B low", int'(count_o), c0);
    @(posedge clk); #2 pin_b_in = 1;
    repeat (12) @(posedge clk);
    #2 pin_b_in = 0;
    cyc(6);
    check("R8", "counts while B high", int'(count_o) - c0, 12);

    // R9 edge modes
    cur_req = "R9";
    wr(0, 32'h21); cyc(3); c0 = int'(count_o);
    pulses(5); cyc(6);
    check("R9", "rising edges", int'(count_o) - c0, 5);
    wr(0, 32'h31); cyc(3); c0 = int'(count_o);
    pulses(5); cyc(6);
    check("R9", "falling edges", int'(count_o) - c0, 5);

    // R11 interrupt views
    cur_req = "R11";
    wr(0, 0); wr(4, 3); wr(2, 0); wr(7, 1); wr(0, 1);
    cyc(10);
    check("R11", "raw on wrap", int'(irq_raw_o), 1);
    check("R11", "status enabled", int'(irq_o), 1);
    wr(0, 0); wr(6, 1); cyc(1);
    check("R11", "raw cleared", int'(irq_raw_o), 0);
    check("R11", "status cleared", int'(irq_o), 0);
    wr(7, 0); wr(8, 1); cyc(1);
    check("R11", "force masked", int'(irq_o), 0);
    wr(7, 1); cyc(1);
    check("R11", "force enabled", int'(irq_o), 1);
    wr(8, 0); cyc(1);
    check("R11", "force removed", int'(irq_o), 0);

    cyc(2);
    summary();
  end
endmodule